// File: doc/BRIEF.md
# Burst Context Tracker and Rule Checker

This block watches the address phase of a pipelined system bus port without driving anything back onto it. It takes the select, ready, transfer-type, address, burst-type and size signals that a subordinate sees. Every cycle in which a transfer is actually accepted, it updates a small record of the burst in flight. The record holds the burst kind, the beat size, the address the next continuation beat must carry and the number of beats still owed.

Three sticky flags report protocol breaches:
- a continuation beat that arrives with no burst open;
- a continuation beat whose address leaves the burst's incrementing or wrapping pattern;
- a fixed-length burst that is abandoned by a fresh start before all of its beats have been seen.

Two free-running counters tally accepted start beats and accepted continuation beats. Their ratio shows how many separate operations a master issues and how long its bursts run. The block sits next to a subordinate or an interconnect port, purely as an observer and profiler.

Top module: `burst_watch`

## Requirements
- R1: The transfer type is decoded as IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10 and SEQ=2'b11. A BUSY beat never changes the context, the beat count or either counter. An IDLE beat changes nothing, except that it closes an open undefined-length burst (see R8).
- R2: A beat is accepted only when `sel_i` and `ready_i` are both high. In any other cycle the context, the flags and both counters keep their values.
- R3: An accepted NONSEQ replaces any earlier context with its own burst type, size and address. The expected next address becomes its address plus 2^size, or the wrapped value for a wrapping burst (R6).
- R4: An accepted SEQ while no burst is open sets `err_orphan_o`.
- R5: An accepted NONSEQ with burst code 3'b000 (single) leaves no burst open, so `ctx_open_o` is low in the next cycle.
- R6: Burst codes are 3'b001 (undefined-length increment), 3'b010/3'b100/3'b110 (wrap over 4/8/16 beats) and 3'b011/3'b101/3'b111 (increment over 4/8/16 beats). For each accepted SEQ the expected address steps by 2^size. For wrapping bursts it stays inside an aligned window of beats × 2^size bytes. An accepted SEQ whose address differs from `exp_addr_o` sets `err_addr_o`, and the expected address then keeps following the computed pattern.
- R7: `nonseq_cnt_o` increments by one on each accepted NONSEQ, and `seq_cnt_o` increments by one on each accepted SEQ, whether or not that beat breaks a rule.
- R8: An accepted NONSEQ that arrives while a fixed-length burst still owes beats sets `err_cut_o`. An undefined-length burst closes without any flag on an accepted NONSEQ or an accepted IDLE.
- R9: `rst_n` is active low and synchronous. It closes the context and clears all flags and both counters.
- R10: Each error flag, once set, stays set until reset.
- R11: A fixed-length burst closes once its last beat has been accepted, so a further SEQ sets `err_orphan_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 1 | Port select for the current address phase |
| ready_i | input | 1 | Ready; high when the address phase is accepted |
| trans_i | input | 2 | Transfer type |
| addr_i | input | AW | Address of the current address phase |
| burst_i | input | 3 | Burst type code |
| size_i | input | 3 | Beat size as log2 of bytes |
| ctx_open_o | output | 1 | A burst context is open |
| exp_addr_o | output | AW | Address the next SEQ beat must carry |
| err_orphan_o | output | 1 | Sticky: SEQ seen with no open burst |
| err_addr_o | output | 1 | Sticky: SEQ address broke the burst pattern |
| err_cut_o | output | 1 | Sticky: fixed-length burst cut short by a NONSEQ |
| nonseq_cnt_o | output | CW | Count of accepted NONSEQ beats |
| seq_cnt_o | output | CW | Count of accepted SEQ beats |

## Verification
The bench targets the wrap point of a wrapping burst. A design that only increments would raise `err_addr_o` on a correct beat that folds back to the window base. It drives beats with select or ready low, and BUSY beats placed mid-burst. A design that ignores the qualifier, or that advances on BUSY, would bump a counter or move the expected address. It closes fixed bursts on their last beat, and ends undefined-length bursts with either IDLE or a new start. An off-by-one beat count, or a design that treats an undefined-length burst as fixed, would set the orphan or cut flag wrongly or fail to set it. It also restarts a burst at a fresh address, where a design that kept the old context would report a false pattern error.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] BU_SINGLE = 3'b000;
    localparam logic [2:0] BU_INCR   = 3'b001;

    // Beat count of a fixed-length burst; 0 for single and undefined length.
    function automatic logic [4:0] burst_beats(input logic [2:0] b);
        case (b[2:1])
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            2'b11:   return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic burst_fixed(input logic [2:0] b);
        return b[2:1] != 2'b00;
    endfunction

    function automatic logic burst_wraps(input logic [2:0] b);
        return burst_fixed(b) && !b[0];
    endfunction

endpackage

// File: rtl/bw_addr_gen.sv
module bw_addr_gen #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_i,
    input  logic [2:0]    size_i,
    input  logic [2:0]    burst_i,
    output logic [AW-1:0] nxt_o
);
    import bw_pkg::*;

    logic [AW-1:0] step;
    logic [AW-1:0] window;
    logic [AW-1:0] mask;
    logic [AW-1:0] bumped;

    always_comb begin
        step   = AW'(1) << size_i;
        window = AW'(burst_beats(burst_i)) * step;
        mask   = window - AW'(1);
        bumped = cur_i + step;
        if (burst_wraps(burst_i))
            nxt_o = (cur_i & ~mask) | (bumped & mask);
        else
            nxt_o = bumped;
    end

endmodule

// File: rtl/bw_event_ctr.sv
module bw_event_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> cnt_q == $past(cnt_q) + CW'(1));                  // R7
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q));                                 // R2

endmodule

// File: rtl/burst_watch.sv
module burst_watch #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          ready_i,
    input  logic [1:0]    trans_i,
    input  logic [AW-1:0] addr_i,
    input  logic [2:0]    burst_i,
    input  logic [2:0]    size_i,
    output logic          ctx_open_o,
    output logic [AW-1:0] exp_addr_o,
    output logic          err_orphan_o,
    output logic          err_addr_o,
    output logic          err_cut_o,
    output logic [CW-1:0] nonseq_cnt_o,
    output logic [CW-1:0] seq_cnt_o
);
    import bw_pkg::*;

    typedef struct packed {
        logic          open;
        logic [2:0]    burst;
        logic [2:0]    size;
        logic [AW-1:0] expect_a;
        logic [4:0]    left;
        logic          e_orph;
        logic          e_addr;
        logic          e_cut;
    } ctx_t;

    ctx_t          st_d, st_q;
    logic          commit;
    logic          is_start, is_cont;
    logic [AW-1:0] nx_start, nx_cont;

    assign commit   = sel_i && ready_i;
    assign is_start = commit && (trans_e'(trans_i) == TR_NONSEQ);
    assign is_cont  = commit && (trans_e'(trans_i) == TR_SEQ);

    bw_addr_gen #(.AW(AW)) u_nx_start (
        .cur_i(addr_i), .size_i(size_i), .burst_i(burst_i), .nxt_o(nx_start)
    );
    bw_addr_gen #(.AW(AW)) u_nx_cont (
        .cur_i(st_q.expect_a), .size_i(st_q.size), .burst_i(st_q.burst), .nxt_o(nx_cont)
    );

    always_comb begin
        st_d = st_q;
        if (commit) begin
            case (trans_e'(trans_i))
                TR_NONSEQ: begin
                    if (st_q.open && burst_fixed(st_q.burst) && st_q.left != 5'd0)
                        st_d.e_cut = 1'b1;
                    st_d.open     = (burst_i != BU_SINGLE);
                    st_d.burst    = burst_i;
                    st_d.size     = size_i;
                    st_d.expect_a = nx_start;
                    st_d.left     = burst_fixed(burst_i) ? burst_beats(burst_i) - 5'd1 : 5'd0;
                end
                TR_SEQ: begin
                    if (!st_q.open) begin
                        st_d.e_orph = 1'b1;
                    end else begin
                        if (addr_i != st_q.expect_a)
                            st_d.e_addr = 1'b1;
                        st_d.expect_a = nx_cont;
                        if (burst_fixed(st_q.burst)) begin
                            st_d.left = st_q.left - 5'd1;
                            if (st_q.left == 5'd1)
                                st_d.open = 1'b0;
                        end
                    end
                end
                TR_IDLE: begin
                    if (st_q.open && st_q.burst == BU_INCR)
                        st_d.open = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bw_event_ctr #(.CW(CW)) u_cnt_start (
        .clk(clk), .rst_n(rst_n), .inc_i(is_start), .cnt_o(nonseq_cnt_o)
    );
    bw_event_ctr #(.CW(CW)) u_cnt_cont (
        .clk(clk), .rst_n(rst_n), .inc_i(is_cont), .cnt_o(seq_cnt_o)
    );

    assign ctx_open_o   = st_q.open;
    assign exp_addr_o   = st_q.expect_a;
    assign err_orphan_o = st_q.e_orph;
    assign err_addr_o   = st_q.e_addr;
    assign err_cut_o    = st_q.e_cut;

    AST_NO_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctx_open_o) && $stable(exp_addr_o)); // R2
    AST_ORPHAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cont && !ctx_open_o) |=> err_orphan_o);              // R4
    AST_SINGLE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_start && burst_i == BU_SINGLE) |=> !ctx_open_o);     // R5
    AST_PATTERN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cont && ctx_open_o && addr_i != exp_addr_o) |=> err_addr_o); // R6
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_orphan_o || err_addr_o || err_cut_o) |=>
        ($past(err_orphan_o) <= err_orphan_o) && ($past(err_addr_o) <= err_addr_o)
        && ($past(err_cut_o) <= err_cut_o));                      // R10
    AST_BUSY_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && trans_e'(trans_i) == TR_BUSY) |=>
        $stable(exp_addr_o) && $stable(ctx_open_o));             // R1

endmodule

// File: tb/sim_burst_watch.sv
module sim_burst_watch;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_i = 1'b0, ready_i = 1'b0;
    logic [1:0]    trans_i = 2'b00;
    logic [AW-1:0] addr_i = '0;
    logic [2:0]    burst_i = 3'b000, size_i = 3'b000;
    logic          ctx_open_o, err_orphan_o, err_addr_o, err_cut_o;
    logic [AW-1:0] exp_addr_o;
    logic [CW-1:0] nonseq_cnt_o, seq_cnt_o;

    always #2 clk = ~clk;

    burst_watch #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .ready_i(ready_i),
        .trans_i(trans_i), .addr_i(addr_i), .burst_i(burst_i), .size_i(size_i),
        .ctx_open_o(ctx_open_o), .exp_addr_o(exp_addr_o),
        .err_orphan_o(err_orphan_o), .err_addr_o(err_addr_o), .err_cut_o(err_cut_o),
        .nonseq_cnt_o(nonseq_cnt_o), .seq_cnt_o(seq_cnt_o)
    );

    typedef struct packed {
        logic          open;
        logic [AW-1:0] ea;
        logic          orph, bad, cut;
        logic [CW-1:0] ns, sq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0, n_bad = 0;

    // reference model state
    logic          m_open;
    logic [2:0]    m_burst, m_size;
    longint        m_ea;
    int            m_left;
    logic          m_orph, m_bad, m_cut;
    logic [CW-1:0] m_ns, m_sq;

    function automatic int beats_of(input logic [2:0] b);
        if (b == 3'b010 || b == 3'b011) return 4;
        if (b == 3'b100 || b == 3'b101) return 8;
        if (b == 3'b110 || b == 3'b111) return 16;
        return 0;
    endfunction

    function automatic longint step_addr(input longint a, input logic [2:0] b, input logic [2:0] z);
        longint by, win, base;
        by = longint'(1) << z;
        if (b == 3'b010 || b == 3'b100 || b == 3'b110) begin
            win  = by * beats_of(b);
            base = a - (a % win);
            return base + ((a + by - base) % win);
        end
        return (a + by) & 64'hFFFF_FFFF;
    endfunction

    task automatic model_reset();
        m_open = 0; m_burst = 0; m_size = 0; m_ea = 0; m_left = 0;
        m_orph = 0; m_bad = 0; m_cut = 0; m_ns = 0; m_sq = 0;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic beat(input logic s, input logic r, input logic [1:0] t,
                        input longint a, input logic [2:0] b, input logic [2:0] z,
                        input string tag);
        exp_t e;
        @(negedge clk);
        sel_i = s; ready_i = r; trans_i = t; addr_i = a[AW-1:0]; burst_i = b; size_i = z;
        if (s && r) begin
            case (t)
                2'b10: begin
                    if (m_open && beats_of(m_burst) != 0 && m_left > 0) m_cut = 1;
                    m_open = (b != 3'b000); m_burst = b; m_size = z;
                    m_ea = step_addr(a, b, z);
                    m_left = beats_of(b) > 0 ? beats_of(b) - 1 : 0;
                    m_ns++;
                end
                2'b11: begin
                    m_sq++;
                    if (!m_open) m_orph = 1;
                    else begin
                        if (a != m_ea) m_bad = 1;
                        m_ea = step_addr(m_ea, m_burst, m_size);
                        if (beats_of(m_burst) != 0) begin
                            m_left--;
                            if (m_left == 0) m_open = 0;
                        end
                    end
                end
                2'b00: if (m_open && m_burst == 3'b001) m_open = 0;
                default: ;
            endcase
        end
        e.open = m_open; e.ea = m_ea[AW-1:0]; e.orph = m_orph; e.bad = m_bad;
        e.cut = m_cut; e.ns = m_ns; e.sq = m_sq;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) beat(0, 1, 2'b00, 0, 0, 0, "R2");
    endtask

    task automatic reset_and_check();
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
        rst_n = 0; sel_i = 0; ready_i = 0; trans_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
        check(!ctx_open_o, "R9", "open", ctx_open_o, 0);
        check({err_orphan_o, err_addr_o, err_cut_o} == 3'b000, "R9", "flags",
              {err_orphan_o, err_addr_o, err_cut_o}, 0);
        check(nonseq_cnt_o == 0 && seq_cnt_o == 0, "R9", "counters",
              {nonseq_cnt_o, seq_cnt_o}, 0);
    endtask

    // monitor: compares each pushed expectation one step after its clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                exp_t  e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(ctx_open_o == e.open, tg, "ctx_open", ctx_open_o, e.open);
                if (e.open)
                    check(exp_addr_o == e.ea, tg, "exp_addr", exp_addr_o, e.ea);
                check(err_orphan_o == e.orph, tg, "err_orphan (R4)", err_orphan_o, e.orph);
                check(err_addr_o == e.bad, tg, "err_addr (R6)", err_addr_o, e.bad);
                check(err_cut_o == e.cut, tg, "err_cut (R8)", err_cut_o, e.cut);
                check(nonseq_cnt_o == e.ns, tg, "nonseq_cnt (R7)", nonseq_cnt_o, e.ns);
                check(seq_cnt_o == e.sq, tg, "seq_cnt (R7)", seq_cnt_o, e.sq);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        reset_and_check();                                          // R9

        // R5 single closes, R4 orphan after it
        beat(1, 1, 2'b10, 32'h100, 3'b000, 3'd2, "R5");
        beat(1, 1, 2'b11, 32'h104, 3'b000, 3'd2, "R4");
        quiet(2);                                                   // R10 sticky
        reset_and_check();

        // R3/R6 INCR4 words with BUSY (R1) and unaccepted beats (R2), then R11
        beat(1, 1, 2'b10, 32'h200, 3'b011, 3'd2, "R3");
        beat(1, 1, 2'b11, 32'h204, 3'b011, 3'd2, "R6");
        beat(1, 1, 2'b01, 32'h208, 3'b011, 3'd2, "R1");
        beat(0, 1, 2'b10, 32'h900, 3'b000, 3'd2, "R2");
        beat(1, 0, 2'b11, 32'h300, 3'b011, 3'd2, "R2");
        beat(1, 1, 2'b11, 32'h208, 3'b011, 3'd2, "R6");
        beat(1, 1, 2'b11, 32'h20C, 3'b011, 3'd2, "R11");
        beat(1, 1, 2'b11, 32'h210, 3'b011, 3'd2, "R11");
        reset_and_check();

        // R6 wrapping: WRAP4 words from 0x38 fold to 0x30
        beat(1, 1, 2'b10, 32'h38, 3'b010, 3'd2, "R6");
        beat(1, 1, 2'b11, 32'h3C, 3'b010, 3'd2, "R6");
        beat(1, 1, 2'b11, 32'h30, 3'b010, 3'd2, "R6");
        beat(1, 1, 2'b11, 32'h34, 3'b010, 3'd2, "R6");
        // WRAP8 halfwords from 0x1E
        beat(1, 1, 2'b10, 32'h1E, 3'b100, 3'd1, "R6");
        for (int i = 0; i < 7; i++)
            beat(1, 1, 2'b11, m_ea, 3'b100, 3'd1, "R6");
        // WRAP16 bytes from 0x4B
        beat(1, 1, 2'b10, 32'h4B, 3'b110, 3'd0, "R6");
        for (int i = 0; i < 15; i++)
            beat(1, 1, 2'b11, m_ea, 3'b110, 3'd0, "R6");
        reset_and_check();

        // R6 pattern break, R10 sticky
        beat(1, 1, 2'b10, 32'h400, 3'b101, 3'd2, "R6");
        beat(1, 1, 2'b11, 32'h404, 3'b101, 3'd2, "R6");
        beat(1, 1, 2'b11, 32'h40C, 3'b101, 3'd2, "R6");
        beat(1, 1, 2'b11, 32'h40C, 3'b101, 3'd2, "R10");
        quiet(1);
        reset_and_check();

        // R8 fixed burst cut short
        beat(1, 1, 2'b10, 32'h500, 3'b111, 3'd2, "R8");
        beat(1, 1, 2'b11, 32'h504, 3'b111, 3'd2, "R8");
        beat(1, 1, 2'b10, 32'h800, 3'b000, 3'd2, "R8");
        quiet(1);
        reset_and_check();

        // R8 undefined length ends cleanly on NONSEQ; R3 new context at fresh address
        beat(1, 1, 2'b10, 32'h600, 3'b001, 3'd3, "R8");
        beat(1, 1, 2'b11, 32'h608, 3'b001, 3'd3, "R8");
        beat(1, 1, 2'b10, 32'h7F0, 3'b001, 3'd2, "R3");
        beat(1, 1, 2'b11, 32'h7F4, 3'b001, 3'd2, "R3");
        beat(1, 1, 2'b11, 32'h7F8, 3'b001, 3'd2, "R3");
        // R8 IDLE closes it, R4 SEQ afterwards is orphan
        beat(1, 1, 2'b00, 32'h0, 3'b001, 3'd2, "R8");
        beat(1, 1, 2'b11, 32'h7FC, 3'b001, 3'd2, "R4");
        quiet(2);

        while (exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule